// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. It runs on the system clock and advances only on a one-cycle conversion-clock enable, `tad_tick`, that marks each conversion-clock period. A start request from software begins a sequence. An optional acquisition window runs first, with a length chosen by a 3-bit code. A binary search follows, one result bit per tick, from the most significant bit down. The trial code goes to an external DAC, and the block reads back an external comparator.

When the last bit is resolved, the block does three things on one clock edge. It loads the 10-bit result into two right-justified 8-bit result registers, drops `busy` and raises a completion flag that stays up until software clears it. Software can abort a running sequence. An abort leaves the result registers exactly as they were.

After a completion or an abort, the block always keeps a fixed two-tick recovery gap before it can run again. During that gap and while idle, the sample switch stays closed, so the analog input is tracked again without any action from software. A start request made during the gap is held and runs as soon as the gap ends.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset: `busy`=0, `done_flag`=0, `res_hi`=`res_lo`=0, `sample_closed`=1, `dac_code`=0.
- R2: When idle with `enable`=1, a `start_set` pulse makes `busy` read 1 on the next cycle.
- R3: `acq_sel` values 0..7 select acquisition lengths of 0, 2, 4, 6, 8, 12, 16 and 20 ticks. When idle, the sequence completes after exactly (acquisition + 10) ticks counted from the start edge. With code 0, conversion starts at once.
- R4: Conversion resolves bits 9 down to 0, one per tick. The trial code is the bits already kept, with the current bit set. The current bit is kept when `cmp_in`=1 (input at or above the trial). The DAC output while idle after reset is 0.
- R5: On the completion edge, the result registers load, `busy` goes 0 and `done_flag` goes 1. `done_flag` stays 1 until a `flag_clr` pulse. If both happen on one edge, setting wins.
- R6: `start_clr` during acquisition or conversion aborts the sequence. On the next cycle `busy` is 0. `done_flag` is not raised, and the result registers keep their previous (completed or software-written) value.
- R7: After a completion or an abort, two ticks pass before a new sequence may start. A `start_set` during that gap is held, shows `busy`=1 and starts when the gap ends. From a completion, that makes (2 + acquisition + 10) ticks.
- R8: `sample_closed` is 0 exactly during the conversion phase (10 ticks) and 1 during acquisition, recovery and idle.
- R9: `start_set` has no effect while `enable`=0.
- R10: The result is right-justified: `res_hi` = {6'b0, result[9:8]}, `res_lo` = result[7:0].
- R11: `wr_hi`/`wr_lo` load `wr_data` into `res_hi`/`res_lo` only while `busy`=0. While `busy`=1 they are ignored.
- R12: `start_clr` takes priority over a `start_set` on the same cycle, so no sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tad_tick | input | 1 | One-cycle pulse per conversion-clock period |
| enable | input | 1 | Module enable; start requests are ignored when 0 |
| start_set | input | 1 | Software start request pulse |
| start_clr | input | 1 | Software abort pulse |
| acq_sel | input | 3 | Acquisition length code |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the DAC trial |
| dac_code | output | 10 | Trial code to the DAC |
| sample_closed | output | 1 | Sample switch closed (tracking input) |
| busy | output | 1 | Sequence requested or running |
| done_flag | output | 1 | Sticky completion flag |
| flag_clr | input | 1 | Clears `done_flag` |
| wr_hi | input | 1 | Software write strobe, upper result register |
| wr_lo | input | 1 | Software write strobe, lower result register |
| wr_data | input | 8 | Software write data |
| res_hi | output | 8 | Upper result register (right-justified) |
| res_lo | output | 8 | Lower result register |

## Verification
A wrong acquisition or recovery count shows up as a tick count from start to `done_flag` that is wrong by the same number of ticks. It is visible within at most 32 ticks of the start. A corrupted bit mask or kept-bit register shows at the DAC pins on the very next tick as a trial code that leaves the binary-search sequence, and later as a wrong result word. A broken abort or busy-write guard shows in the result registers one cycle after the offending edge.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int ACQ_MAX = 20;
    localparam int CNT_W   = $clog2(ACQ_MAX + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACQ   = 2'd1,
        ST_CONV  = 2'd2,
        ST_RECOV = 2'd3
    } seq_state_e;

    // Acquisition length in ticks: steps of 2 up to code 4, then steps of 4.
    function automatic logic [CNT_W-1:0] acq_ticks(input logic [2:0] code);
        int c;
        c = int'(code);
        if (c <= 4) return CNT_W'(2 * c);
        return CNT_W'(4 * (c - 2));
    endfunction

endpackage

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         cmp_in,
    output logic [W-1:0] trial,
    output logic [W-1:0] final_word,
    output logic         last
);

    typedef struct packed {
        logic [W-1:0] kept;
        logic [W-1:0] mask;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        if (load) begin
            eng_d.kept = '0;
            eng_d.mask = {1'b1, {(W-1){1'b0}}};
        end else if (step) begin
            if (cmp_in) eng_d.kept = eng_q.kept | eng_q.mask;
            eng_d.mask = eng_q.mask >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign trial      = eng_q.kept | eng_q.mask;
    assign last       = eng_q.mask[0];
    assign final_word = cmp_in ? (eng_q.kept | eng_q.mask) : eng_q.kept;

    // R4
    mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_q.mask));

    // R4
    step_has_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |-> (eng_q.mask != '0));

endmodule

// File: rtl/sar_result_regs.sv
module sar_result_regs #(
    parameter int RES_W = 10,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             load,
    input  logic [RES_W-1:0] value,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] res_hi,
    output logic [REG_W-1:0] res_lo
);

    typedef struct packed {
        logic [REG_W-1:0] hi;
        logic [REG_W-1:0] lo;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (load) begin
            res_d.hi = REG_W'(value >> REG_W);
            res_d.lo = value[REG_W-1:0];
        end else if (!busy) begin
            if (wr_hi) res_d.hi = wr_data;
            if (wr_lo) res_d.lo = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_hi = res_q.hi;
    assign res_lo = res_q.lo;

    // R11
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> $stable(res_q));

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int REG_W    = 8,
    parameter int GAP_TADS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tad_tick,
    input  logic             enable,
    input  logic             start_set,
    input  logic             start_clr,
    input  logic [2:0]       acq_sel,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic             sample_closed,
    output logic             busy,
    output logic             done_flag,
    input  logic             flag_clr,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] res_hi,
    output logic [REG_W-1:0] res_lo
);

    localparam logic [CNT_W-1:0] GAP_CNT = CNT_W'(GAP_TADS);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             pend;
        logic             irq;
    } ctl_t;

    ctl_t cur_q, nx_d;

    logic             eng_load, eng_step, res_load, go, start_ok, conv_last;
    logic [CNT_W-1:0] acq_len;
    logic [RES_W-1:0] final_word;

    assign start_ok = start_set && enable && !start_clr;
    assign acq_len  = acq_ticks(acq_sel);

    always_comb begin
        nx_d     = cur_q;
        eng_load = 1'b0;
        eng_step = 1'b0;
        res_load = 1'b0;
        go       = 1'b0;
        if (flag_clr) nx_d.irq = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (start_ok) begin
                    nx_d.busy = 1'b1;
                    go        = 1'b1;
                end
            end
            ST_ACQ: begin
                if (start_clr) begin
                    nx_d.busy  = 1'b0;
                    nx_d.state = ST_RECOV;
                    nx_d.cnt   = GAP_CNT;
                end else if (tad_tick) begin
                    if (cur_q.cnt == CNT_W'(1)) begin
                        nx_d.state = ST_CONV;
                        eng_load   = 1'b1;
                    end else begin
                        nx_d.cnt = cur_q.cnt - CNT_W'(1);
                    end
                end
            end
            ST_CONV: begin
                if (start_clr) begin
                    nx_d.busy  = 1'b0;
                    nx_d.state = ST_RECOV;
                    nx_d.cnt   = GAP_CNT;
                end else if (tad_tick) begin
                    eng_step = 1'b1;
                    if (conv_last) begin
                        res_load   = 1'b1;
                        nx_d.busy  = 1'b0;
                        nx_d.irq   = 1'b1;
                        nx_d.state = ST_RECOV;
                        nx_d.cnt   = GAP_CNT;
                    end
                end
            end
            ST_RECOV: begin
                if (start_clr) begin
                    nx_d.pend = 1'b0;
                    nx_d.busy = 1'b0;
                end else if (start_ok) begin
                    nx_d.pend = 1'b1;
                    nx_d.busy = 1'b1;
                end
                if (tad_tick) begin
                    if (cur_q.cnt == CNT_W'(1)) begin
                        if (nx_d.pend) begin
                            nx_d.pend = 1'b0;
                            go        = 1'b1;
                        end else begin
                            nx_d.state = ST_IDLE;
                        end
                    end else begin
                        nx_d.cnt = cur_q.cnt - CNT_W'(1);
                    end
                end
            end
            default: nx_d.state = ST_IDLE;
        endcase
        if (go) begin
            if (acq_len == '0) begin
                nx_d.state = ST_CONV;
                eng_load   = 1'b1;
            end else begin
                nx_d.state = ST_ACQ;
                nx_d.cnt   = acq_len;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nx_d;
    end

    sar_bit_engine #(.W(RES_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (eng_load),
        .step       (eng_step),
        .cmp_in     (cmp_in),
        .trial      (dac_code),
        .final_word (final_word),
        .last       (conv_last)
    );

    sar_result_regs #(.RES_W(RES_W), .REG_W(REG_W)) u_results (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (cur_q.busy),
        .load    (res_load),
        .value   (final_word),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .wr_data (wr_data),
        .res_hi  (res_hi),
        .res_lo  (res_lo)
    );

    assign sample_closed = (cur_q.state != ST_CONV);
    assign busy          = cur_q.busy;
    assign done_flag     = cur_q.irq;

    // R5
    finish_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_CONV && tad_tick && conv_last && !start_clr)
        |=> (!cur_q.busy && cur_q.irq && cur_q.state == ST_RECOV));

    // R6
    abort_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.state == ST_ACQ || cur_q.state == ST_CONV) && start_clr)
        |=> (!cur_q.busy && cur_q.state == ST_RECOV));

    // R7
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_RECOV && !tad_tick) |=> (cur_q.state == ST_RECOV));

    // R9
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_IDLE && !enable) |=> (cur_q.state == ST_IDLE));

    // R3
    acq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_ACQ) |-> (cur_q.cnt != '0 && int'(cur_q.cnt) <= ACQ_MAX));

endmodule

// File: tb/sar_seq_ctrl_bench.sv
module sar_seq_ctrl_bench;

    localparam time CLK_HALF = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tad_tick = 1'b0;
    logic       enable = 1'b0;
    logic       start_set = 1'b0;
    logic       start_clr = 1'b0;
    logic [2:0] acq_sel = 3'd0;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic       sample_closed, busy, done_flag;
    logic       flag_clr = 1'b0;
    logic       wr_hi = 1'b0, wr_lo = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] res_hi, res_lo;

    logic [9:0] vin = 10'd0;
    logic [1:0] div = 2'd0;

    int checks = 0;
    int bad = 0;
    logic [15:0] exp_q[$];
    logic        flag_prev = 1'b0;

    int acq_tbl[8] = '{0, 2, 4, 6, 8, 12, 16, 20};

    always #CLK_HALF clk = ~clk;

    // Comparator model: input at or above the trial code.
    assign cmp_in = (vin >= dac_code);

    // Tick generator: one pulse every 4 clocks, changed at the rising edge.
    always @(posedge clk) begin
        div      <= div + 2'd1;
        tad_tick <= (div == 2'd2);
    end

    sar_seq_ctrl u_sar_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .tad_tick(tad_tick), .enable(enable),
        .start_set(start_set), .start_clr(start_clr), .acq_sel(acq_sel),
        .cmp_in(cmp_in), .dac_code(dac_code), .sample_closed(sample_closed),
        .busy(busy), .done_flag(done_flag), .flag_clr(flag_clr),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
        .res_hi(res_hi), .res_lo(res_lo)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: each rising completion flag pops one expected result.
    always @(negedge clk) begin
        if (rst_n && done_flag && !flag_prev) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected completion", {16'h0, res_hi, res_lo}, 32'h0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk({res_hi, res_lo} == e, "R4/R10 result word",
                    {16'h0, res_hi, res_lo}, {16'h0, e});
            end
        end
        flag_prev = done_flag;
    end

    task automatic wait_ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            if (tad_tick) k++;
        end
        @(negedge clk);
    endtask

    // Driver: pushes the expected result, starts, counts ticks and trials.
    task automatic run_seq(input logic [9:0] v, input logic [2:0] code,
                           input bit b2b, input string tag);
        int nt = 0;
        int no = 0;
        int trial_bad = 0;
        int guard = 0;
        int exp_ticks;
        logic [9:0] kept = '0;
        int bitpos = 9;
        vin = v;
        acq_sel = code;
        exp_q.push_back({6'b0, v[9:8], v[7:0]});
        start_set = 1'b1;
        if (b2b) flag_clr = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        flag_clr = 1'b0;
        chk(busy == 1'b1, {tag, " R2 busy after start"}, {31'h0, busy}, 32'h1);
        while (!done_flag && guard < 2000) begin
            if (tad_tick) begin
                nt++;
                if (!sample_closed) begin
                    logic [9:0] t;
                    no++;
                    t = kept | (10'd1 << bitpos);
                    if (dac_code != t) trial_bad++;
                    if (v >= t) kept = t;
                    bitpos--;
                end
            end
            guard++;
            @(negedge clk);
        end
        exp_ticks = acq_tbl[code] + 10 + (b2b ? 2 : 0);
        chk(nt == exp_ticks, {tag, b2b ? " R7 ticks incl gap" : " R3 ticks to done"},
            nt, exp_ticks);
        chk(no == 10, {tag, " R8 open-switch ticks"}, no, 10);
        chk(trial_bad == 0, {tag, " R4 trial sequence"}, trial_bad, 0);
        chk(busy == 1'b0 && done_flag == 1'b1, {tag, " R5 busy low flag high"},
            {30'h0, busy, done_flag}, 32'h1);
        chk(sample_closed == 1'b1, {tag, " R8 switch closed after done"},
            {31'h0, sample_closed}, 32'h1);
    endtask

    task automatic settle();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        repeat (16) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 0);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done_flag == 1'b0, "R1 flag", done_flag, 0);
        chk({res_hi, res_lo} == 16'h0, "R1 results", {res_hi, res_lo}, 0);
        chk(sample_closed == 1'b1, "R1 switch", sample_closed, 1);
        chk(dac_code == 10'h0, "R1 dac", dac_code, 0);

        // R9: start while disabled
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        chk(busy == 1'b0, "R9 busy stays low", busy, 0);
        wait_ticks(25);
        chk(busy == 1'b0 && done_flag == 1'b0 && sample_closed == 1'b1,
            "R9 no sequence", {busy, done_flag, sample_closed}, 3'b001);

        enable = 1'b1;
        // R12: abort and start on the same cycle
        start_set = 1'b1;
        start_clr = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        start_clr = 1'b0;
        chk(busy == 1'b0, "R12 clear wins", busy, 0);
        wait_ticks(3);
        chk(sample_closed == 1'b1 && done_flag == 1'b0, "R12 no sequence",
            {done_flag, sample_closed}, 2'b01);

        // R11: idle writes accepted
        wr_hi = 1'b1; wr_data = 8'hA5;
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 8'h3C;
        @(negedge clk);
        wr_lo = 1'b0;
        chk(res_hi == 8'hA5, "R11 idle write hi", res_hi, 8'hA5);
        chk(res_lo == 8'h3C, "R11 idle write lo", res_lo, 8'h3C);

        // R11/R6: busy write ignored, then abort keeps software value
        vin = 10'h2F0;
        acq_sel = 3'd7;
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        wait_ticks(5);
        wr_lo = 1'b1; wr_data = 8'hFF;
        @(negedge clk);
        wr_lo = 1'b0;
        chk(res_lo == 8'h3C, "R11 busy write ignored", res_lo, 8'h3C);
        while (sample_closed) @(negedge clk);
        wait_ticks(3);
        start_clr = 1'b1;
        @(negedge clk);
        start_clr = 1'b0;
        chk(busy == 1'b0, "R6 busy after abort", busy, 0);
        chk(sample_closed == 1'b1, "R8 switch closed after abort", sample_closed, 1);
        wait_ticks(20);
        chk(done_flag == 1'b0, "R6 no flag on abort", done_flag, 0);
        chk({res_hi, res_lo} == 16'hA53C, "R6 results kept", {res_hi, res_lo}, 16'hA53C);

        // R3/R4/R8/R10 across codes and input patterns
        run_seq(10'h155, 3'd0, 1'b0, "c0");
        repeat (8) @(negedge clk);
        chk(done_flag == 1'b1, "R5 flag sticky", done_flag, 1);
        settle();
        chk(done_flag == 1'b0, "R5 flag cleared", done_flag, 0);
        run_seq(10'h3FF, 3'd2, 1'b0, "c2");
        settle();
        run_seq(10'h000, 3'd7, 1'b0, "c7");
        settle();
        run_seq(10'h2AA, 3'd5, 1'b0, "c5");
        chk(res_hi == 8'h02 && res_lo == 8'hAA, "R10 justification",
            {res_hi, res_lo}, 16'h02AA);
        settle();
        run_seq(10'h200, 3'd1, 1'b0, "c1");
        settle();
        run_seq(10'h1C7, 3'd4, 1'b0, "c4");
        // R7: start held through the recovery gap
        run_seq(10'h0F0, 3'd0, 1'b1, "b2b");
        run_seq(10'h301, 3'd3, 1'b1, "b2b3");
        settle();
        chk(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule